// File: doc/BRIEF.md
# Sleep-Pin Power-State Sequencer

This block models the power-state machine on the device side of a self-refreshing pseudo-SRAM. It watches the chip-select, sleep and write-strobe pins (all active low) and a few fields of the device configuration register, and it reports which power state the device is in. The states are initialization, standby, active, partial refresh and deep power-down. It also flags when reads and writes must be ignored, tells an outside configuration register when and what to load, and gives the address window that a partial refresh would keep alive. Time is counted in clock cycles, and the three timing limits are parameters.

There are two ways the sleep pin is used. A short low pulse on it, followed within a bounded number of cycles by a write strobe, opens a configuration load: the address bus value is handed to the register on whichever of the write strobe or chip select rises first. If instead the sleep pin is held low with the chip deselected for the full sleep delay, the device drops into partial refresh or deep power-down, and the sleep-mode bit decides which. Leaving partial refresh is immediate. Leaving deep power-down runs a full re-initialization. A register load done through the software sequence stops the sleep pin from starting partial refresh until the next reset.

Top module: `psram_sleep_seq`

## Requirements
- R1: After reset is released, `pwrState` reads INIT (code 0) for exactly INIT_CYCLES clock edges. It then reads STANDBY (code 1) if `ceN` is high.
- R2: On the first clock edge after reset is released, `cfgLoad` pulses for one cycle with `cfgData` equal to 0x0070.
- R3: Outside INIT, holding `zzN` low and `ceN` high for SLEEP_CYCLES consecutive edges enters PAR (code 3) when `sleepBit` is 1, or DPD (code 4) when it is 0. Raising `zzN` or lowering `ceN` before then restarts the count.
- R4: Raising `zzN` in DPD moves the state to INIT on the next edge. The state stays in INIT for INIT_CYCLES edges before normal operation resumes.
- R5: Raising `zzN` in PAR returns the state to STANDBY or ACTIVE on the next edge, with no re-initialization.
- R6: A falling `weN` with `ceN` low, seen between LOAD_MIN and LOAD_MAX edges after `zzN` is first seen low, arms a load. On the first edge where `weN` or `ceN` is seen risen, `cfgLoad` pulses for one cycle and `cfgData` carries the last `addrIn` sampled while both strobes were low. A `weN` fall later than LOAD_MAX produces no load.
- R7: `ignoreAccess` is 1 in INIT, PAR and DPD, and 0 in STANDBY and ACTIVE.
- R8: The refresh window follows `parField`. 000 gives the whole array. 001, 010 and 011 give the bottom half, quarter and eighth. 100 gives none (`winNone`=1). 101, 110 and 111 give the top half, quarter and eighth. Bounds are inclusive. With a 22-bit address, the bottom half is 0x000000 to 0x1FFFFF and the top eighth is 0x380000 to 0x3FFFFF.
- R9: After a `swCfgLoad` pulse, holding `zzN` low never enters PAR until reset. DPD entry with `sleepBit`=0 still works.
- R10: Outside INIT, PAR and DPD, the state is ACTIVE (code 2) while `ceN` is low and STANDBY (code 1) while it is high, one edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Power-up reset, active low |
| ceN | input | 1 | Chip select, active low |
| zzN | input | 1 | Sleep pin, active low |
| weN | input | 1 | Write strobe, active low |
| addrIn | input | ADDR_W | Address bus, the source of configuration loads |
| sleepBit | input | 1 | Sleep-mode register bit: 1 selects partial refresh, 0 selects deep power-down |
| parField | input | 3 | Partial-refresh coverage field of the register |
| swCfgLoad | input | 1 | Pulse marking a completed software-sequence register load |
| pwrState | output | 3 | Current power state (0 INIT, 1 STANDBY, 2 ACTIVE, 3 PAR, 4 DPD) |
| ignoreAccess | output | 1 | Reads and writes must be ignored |
| winNone | output | 1 | No part of the array is refreshed |
| winStart | output | ADDR_W | First refreshed address (inclusive) |
| winEnd | output | ADDR_W | Last refreshed address (inclusive) |
| cfgLoad | output | 1 | One-cycle strobe to load the configuration register |
| cfgData | output | ADDR_W | Value to load with `cfgLoad` |

## Verification
The bench checks the state at the cycle just before each timed transition and at the cycle of the transition itself. A sequencer with a sleep or init counter that is off by one edge would switch one check too early or too late. A sleep count that a brief chip select restarts is driven to the full delay again. A design that forgot to restart the count would fall asleep early. Configuration loads are tried both inside and past the window after the sleep pin falls. A design that ignored the window would load the late address. The software lock is exercised with the sleep bit set and then cleared, and all eight coverage codes are walked. A swapped top/bottom mapping, or a "none" code that still reports a range, would show up in those checks.

// File: rtl/psram_sleep_pkg.sv
package psram_sleep_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_STANDBY = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_PAR     = 3'd3,
    ST_DPD     = 3'd4
  } pwrState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDefault;  // push the power-up register value
    logic captureAddr;  // sample the address bus for a pending load
    logic fireLoad;     // emit the armed load
  } seqStrobe_t;

  localparam logic [15:0] CFG_DEFAULT = 16'h0070;

endpackage

// File: rtl/psram_sleep_ctrl.sv
module psram_sleep_ctrl
  import psram_sleep_pkg::*;
#(
  parameter int INIT_CYCLES  = 15000,
  parameter int SLEEP_CYCLES = 1000,
  parameter int LOAD_MIN     = 1,
  parameter int LOAD_MAX     = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       zzN,
  input  logic       weN,
  input  logic       sleepBit,
  input  logic       swCfgLoad,
  output pwrState_e  state,
  output logic       ignoreAccess,
  output seqStrobe_t strb
);

  localparam int IW = $clog2(INIT_CYCLES);
  localparam int SW = $clog2(SLEEP_CYCLES);
  localparam int CW = $clog2(LOAD_MAX + 2);
  localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_CYCLES - 1);
  localparam logic [SW-1:0] SLEEP_LAST = SW'(SLEEP_CYCLES - 1);
  localparam logic [CW-1:0] WIN_LO     = CW'(LOAD_MIN);
  localparam logic [CW-1:0] WIN_HI     = CW'(LOAD_MAX);

  logic [IW-1:0] initCnt;
  logic [SW-1:0] sleepCnt;
  logic [CW-1:0] winCnt;
  logic zzPrev, wePrev, cePrev;
  logic armed, swLocked, defaultPending;
  pwrState_e nextState;

  logic normal, sleepHit, winOpen, armSet, fire;

  assign normal   = (state == ST_STANDBY) || (state == ST_ACTIVE);
  assign sleepHit = normal && !zzN && ceN && (sleepCnt == SLEEP_LAST);
  assign winOpen  = (winCnt >= WIN_LO) && (winCnt <= WIN_HI);
  assign armSet   = normal && wePrev && !weN && !ceN && !zzN && winOpen;
  assign fire     = armed && ((weN && !wePrev) || (ceN && !cePrev));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_INIT:
        if (initCnt == INIT_LAST) nextState = ceN ? ST_STANDBY : ST_ACTIVE;
      ST_STANDBY, ST_ACTIVE: begin
        nextState = ceN ? ST_STANDBY : ST_ACTIVE;
        if (sleepHit) begin
          if (!sleepBit)      nextState = ST_DPD;
          else if (!swLocked) nextState = ST_PAR;
        end
      end
      ST_PAR:
        if (zzN) nextState = ceN ? ST_STANDBY : ST_ACTIVE;
      ST_DPD:
        if (zzN) nextState = ST_INIT;
      default: nextState = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_INIT;
      initCnt        <= '0;
      sleepCnt       <= '0;
      winCnt         <= '0;
      zzPrev         <= 1'b1;
      wePrev         <= 1'b1;
      cePrev         <= 1'b1;
      armed          <= 1'b0;
      swLocked       <= 1'b0;
      defaultPending <= 1'b1;
    end else begin
      state    <= nextState;
      initCnt  <= (state == ST_INIT && nextState == ST_INIT) ? initCnt + 1'b1 : '0;
      if (normal && !zzN && ceN)
        sleepCnt <= (sleepCnt == SLEEP_LAST) ? sleepCnt : sleepCnt + 1'b1;
      else
        sleepCnt <= '0;
      if (zzN)                 winCnt <= '0;
      else if (zzPrev)         winCnt <= CW'(1);
      else if (winCnt <= WIN_HI) winCnt <= winCnt + 1'b1;
      zzPrev <= zzN;
      wePrev <= weN;
      cePrev <= ceN;
      if (fire || (ceN && weN)) armed <= 1'b0;
      else if (armSet)          armed <= 1'b1;
      swLocked       <= swLocked | swCfgLoad;
      defaultPending <= 1'b0;
    end
  end

  assign ignoreAccess     = (state == ST_INIT) || (state == ST_PAR) || (state == ST_DPD);
  assign strb.loadDefault = defaultPending;
  assign strb.captureAddr = (armed || armSet) && !weN && !ceN;
  assign strb.fireLoad    = fire;

  // R1: initialization never jumps straight into a sleep state
  a_r1_init_exit: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_INIT |=> (state == ST_INIT || state == ST_STANDBY || state == ST_ACTIVE));

  // R3: a sleep state is entered only from a sleep-pin-low, deselected cycle
  a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PAR || state == ST_DPD) &&
     !($past(state) == ST_PAR || $past(state) == ST_DPD)) |-> $past(!zzN && ceN));

  // R4: deep power-down exit goes through initialization
  a_r4_dpd_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DPD && zzN) |=> state == ST_INIT);

  // R5: partial refresh exit is immediate
  a_r5_par_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAR && zzN) |=> (state == ST_STANDBY || state == ST_ACTIVE));

  // R9: once locked, partial refresh is never entered
  a_r9_sw_lock: assert property (@(posedge clk) disable iff (!rstN)
    (swLocked && state != ST_PAR) |=> state != ST_PAR);

endmodule

// File: rtl/psram_sleep_dp.sv
module psram_sleep_dp
  import psram_sleep_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        parField,
  output logic              cfgLoad,
  output logic [ADDR_W-1:0] cfgData,
  output logic              winNone,
  output logic [ADDR_W-1:0] winStart,
  output logic [ADDR_W-1:0] winEnd
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [ADDR_W-1:0] addrHold;
  logic [ADDR_W-1:0] span;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      cfgLoad  <= 1'b0;
      cfgData  <= '0;
    end else begin
      if (strb.captureAddr) addrHold <= addrIn;
      cfgLoad <= strb.fireLoad | strb.loadDefault;
      if (strb.loadDefault)   cfgData <= ADDR_W'(CFG_DEFAULT);
      else if (strb.fireLoad) cfgData <= addrHold;
    end
  end

  // Coverage window: the low two bits select the fraction, the top bit the end
  always_comb begin
    span     = ADDR_TOP >> parField[1:0];
    winNone  = (parField == 3'b100);
    winStart = '0;
    winEnd   = span;
    if (winNone) begin
      winEnd = '0;
    end else if (parField[2]) begin
      winStart = ADDR_TOP - span;
      winEnd   = ADDR_TOP;
    end
  end

  // R6: a load strobe lasts exactly one cycle
  a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !cfgLoad);

  // R8: a reported window is never inverted
  a_r8_window_order: assert property (@(posedge clk) disable iff (!rstN)
    !winNone |-> (winStart <= winEnd));

endmodule

// File: rtl/psram_sleep_seq.sv
module psram_sleep_seq
  import psram_sleep_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int INIT_CYCLES  = 15000,
  parameter int SLEEP_CYCLES = 1000,
  parameter int LOAD_MIN     = 1,
  parameter int LOAD_MAX     = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              zzN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              sleepBit,
  input  logic [2:0]        parField,
  input  logic              swCfgLoad,
  output logic [2:0]        pwrState,
  output logic              ignoreAccess,
  output logic              winNone,
  output logic [ADDR_W-1:0] winStart,
  output logic [ADDR_W-1:0] winEnd,
  output logic              cfgLoad,
  output logic [ADDR_W-1:0] cfgData
);

  pwrState_e  state;
  seqStrobe_t strb;

  psram_sleep_ctrl #(
    .INIT_CYCLES (INIT_CYCLES),
    .SLEEP_CYCLES(SLEEP_CYCLES),
    .LOAD_MIN    (LOAD_MIN),
    .LOAD_MAX    (LOAD_MAX)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .zzN         (zzN),
    .weN         (weN),
    .sleepBit    (sleepBit),
    .swCfgLoad   (swCfgLoad),
    .state       (state),
    .ignoreAccess(ignoreAccess),
    .strb        (strb)
  );

  psram_sleep_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrIn  (addrIn),
    .parField(parField),
    .cfgLoad (cfgLoad),
    .cfgData (cfgData),
    .winNone (winNone),
    .winStart(winStart),
    .winEnd  (winEnd)
  );

  assign pwrState = state;

endmodule

// File: tb/psram_sleep_seq_tb_top.sv
module psram_sleep_seq_tb_top;

  localparam int AW    = 22;
  localparam int INITC = 200;
  localparam int SLPC  = 40;
  localparam int LMAX  = 10;

  localparam logic [2:0] S_INIT = 3'd0, S_STBY = 3'd1, S_ACT = 3'd2,
                         S_PAR = 3'd3, S_DPD = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, zzN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic sleepBit = 1'b1;
  logic [2:0] parField = 3'b000;
  logic swCfgLoad = 1'b0;
  logic [2:0] pwrState;
  logic ignoreAccess, winNone, cfgLoad;
  logic [AW-1:0] winStart, winEnd, cfgData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  psram_sleep_seq #(
    .ADDR_W(AW), .INIT_CYCLES(INITC), .SLEEP_CYCLES(SLPC),
    .LOAD_MIN(1), .LOAD_MAX(LMAX)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .zzN(zzN), .weN(weN),
    .addrIn(addrIn), .sleepBit(sleepBit), .parField(parField),
    .swCfgLoad(swCfgLoad), .pwrState(pwrState), .ignoreAccess(ignoreAccess),
    .winNone(winNone), .winStart(winStart), .winEnd(winEnd),
    .cfgLoad(cfgLoad), .cfgData(cfgData)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    tick(2);
    rstN = 1'b1;
    check("R1 state held in reset", 32'(pwrState), 32'(S_INIT));
    check("R7 ignore during init", 32'(ignoreAccess), 1);
    tick(1);
    check("R2 default load strobe", 32'(cfgLoad), 1);
    check("R2 default load value", 32'(cfgData), 32'h0070);
    tick(1);
    check("R2 strobe one cycle", 32'(cfgLoad), 0);
    tick(INITC - 3);
    check("R1 still init one edge early", 32'(pwrState), 32'(S_INIT));
    tick(1);
    check("R1 standby after init", 32'(pwrState), 32'(S_STBY));
    check("R7 no ignore in standby", 32'(ignoreAccess), 0);
  endtask

  task automatic t_active;
    ceN = 1'b0;
    tick(1);
    check("R10 active while selected", 32'(pwrState), 32'(S_ACT));
    check("R7 no ignore in active", 32'(ignoreAccess), 0);
    ceN = 1'b1;
    tick(1);
    check("R10 back to standby", 32'(pwrState), 32'(S_STBY));
  endtask

  task automatic t_cfg_load;
    zzN = 1'b0;
    tick(1);
    ceN = 1'b0; weN = 1'b0; addrIn = 22'h0000A5;
    tick(2);
    weN = 1'b1; addrIn = 22'h3C0001;
    tick(1);
    check("R6 load strobe in window", 32'(cfgLoad), 1);
    check("R6 load value", 32'(cfgData), 32'h0000A5);
    tick(1);
    check("R6 load single cycle", 32'(cfgLoad), 0);
    ceN = 1'b1; zzN = 1'b1;
    tick(2);
  endtask

  task automatic t_cfg_late;
    int seen = 0;
    zzN = 1'b0;
    tick(LMAX + 3);
    ceN = 1'b0; weN = 1'b0; addrIn = 22'h000033;
    tick(2);
    weN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      if (cfgLoad) seen++;
    end
    check("R6 late write does not load", 32'(seen), 0);
    ceN = 1'b1; zzN = 1'b1;
    tick(2);
  endtask

  task automatic t_par;
    sleepBit = 1'b1;
    zzN = 1'b0;
    tick(SLPC - 1);
    check("R3 not asleep one edge early", 32'(pwrState), 32'(S_STBY));
    tick(1);
    check("R3 enters partial refresh", 32'(pwrState), 32'(S_PAR));
    check("R7 ignore in partial refresh", 32'(ignoreAccess), 1);
    zzN = 1'b1;
    tick(1);
    check("R5 partial refresh exits at once", 32'(pwrState), 32'(S_STBY));
  endtask

  task automatic t_interrupt;
    zzN = 1'b0;
    tick(SLPC - 5);
    ceN = 1'b0;
    tick(1);
    ceN = 1'b1;
    tick(SLPC - 1);
    check("R3 count restarted by select", 32'(pwrState), 32'(S_STBY));
    tick(1);
    check("R3 sleeps after full delay", 32'(pwrState), 32'(S_PAR));
    zzN = 1'b1;
    tick(1);
  endtask

  task automatic t_dpd;
    sleepBit = 1'b0;
    zzN = 1'b0;
    tick(SLPC);
    check("R3 enters deep power-down", 32'(pwrState), 32'(S_DPD));
    check("R7 ignore in deep power-down", 32'(ignoreAccess), 1);
    zzN = 1'b1;
    tick(1);
    check("R4 exit goes to init", 32'(pwrState), 32'(S_INIT));
    tick(INITC - 1);
    check("R4 init lasts full time", 32'(pwrState), 32'(S_INIT));
    tick(1);
    check("R4 normal after re-init", 32'(pwrState), 32'(S_STBY));
  endtask

  task automatic t_window;
    logic [AW-1:0] expS [8];
    logic [AW-1:0] expE [8];
    expS = '{22'h0, 22'h0, 22'h0, 22'h0, 22'h0, 22'h200000, 22'h300000, 22'h380000};
    expE = '{22'h3FFFFF, 22'h1FFFFF, 22'h0FFFFF, 22'h07FFFF, 22'h0,
             22'h3FFFFF, 22'h3FFFFF, 22'h3FFFFF};
    for (int c = 0; c < 8; c++) begin
      parField = 3'(c);
      #1;
      check($sformatf("R8 none flag code %0d", c), 32'(winNone), (c == 4) ? 1 : 0);
      if (c != 4) begin
        check($sformatf("R8 start code %0d", c), 32'(winStart), 32'(expS[c]));
        check($sformatf("R8 end code %0d", c), 32'(winEnd), 32'(expE[c]));
      end
    end
  endtask

  task automatic t_swlock;
    swCfgLoad = 1'b1;
    tick(1);
    swCfgLoad = 1'b0;
    sleepBit = 1'b1;
    zzN = 1'b0;
    tick(SLPC + 5);
    check("R9 locked pin does not start partial refresh", 32'(pwrState), 32'(S_STBY));
    zzN = 1'b1;
    tick(1);
    sleepBit = 1'b0;
    zzN = 1'b0;
    tick(SLPC);
    check("R9 deep power-down still allowed", 32'(pwrState), 32'(S_DPD));
    zzN = 1'b1;
    tick(INITC + 1);
    check("R9 recovers after lock", 32'(pwrState), 32'(S_STBY));
  endtask

  initial begin
    t_reset();
    t_active();
    t_cfg_load();
    t_cfg_late();
    t_par();
    t_interrupt();
    t_dpd();
    t_window();
    t_swlock();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule